// File: doc/BRIEF.md
# Pipeline Penalty Performance Counters

This block watches a pipelined processor's control outputs and measures how far the machine falls short of one instruction per cycle. A per-cycle retire strobe counts useful instructions that complete. Three hazard pulses from the pipeline control unit each add a fixed number of lost bubble cycles to a counter of their own: a load/use interlock costs one bubble, a mispredicted branch costs two, and a return costs three. All four counters saturate at their largest value and are cleared together by a synchronous clear input.

A snapshot input freezes all four counts in the same cycle, so the ratios are consistent, and starts a sequential divider. The divider produces the cycles-per-instruction figure, (instructions + bubbles) / instructions, and the three per-cause penalty terms, bubbles of one cause / instructions. All four ratios are unsigned fixed point with eight fractional bits and are truncated. A done flag marks the results as valid. With 100 instructions, 9 load/use events, 8 mispredicts and 2 returns, the block reports penalty terms of 0.09, 0.16 and 0.06 and a CPI of 1.31, each truncated to the nearest 1/256 below.

Top module: `pipe_perf_counters`

## Requirements
- R1: Every cycle with the retire input high adds exactly one to the instruction count.
- R2: Every cycle with the load/use input high adds one to the load bubble count.
- R3: Every cycle with the mispredict input high adds two to the mispredict bubble count.
- R4: Every cycle with the return input high adds three to the return bubble count.
- R5: A counter whose next value would exceed 2^CW-1 holds at 2^CW-1 and does not wrap.
- R6: A high clear input zeroes all four counters at the next edge, even if event inputs are high in that cycle. It leaves the ratio outputs unchanged.
- R7: A snapshot accepted while idle captures the four counts as they stood before that edge's own increments. It raises busy and lowers done at the next edge.
- R8: The CPI output equals floor(256 * (instr + load + mispredict + return bubbles) / instr).
- R9: Each penalty output equals floor(256 * bubbles of that cause / instr).
- R10: When the captured instruction count is zero, all four ratio outputs are zero when done rises.
- R11: A snapshot that arrives while busy is ignored. The results that follow belong to the earlier snapshot.
- R12: Done rises when busy falls. Done and all ratio outputs then hold until the next accepted snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Synchronous clear of all four counters |
| snapshot_i | input | 1 | Capture counts and start the ratio computation |
| retire_i | input | 1 | A useful instruction completed this cycle |
| load_use_i | input | 1 | Load/use interlock detected this cycle |
| mispredict_i | input | 1 | Branch misprediction detected this cycle |
| return_i | input | 1 | Return instruction detected this cycle |
| instr_count_o | output | CW | Live useful-instruction count |
| load_bub_o | output | CW | Live load/use bubble count |
| mispredict_bub_o | output | CW | Live mispredict bubble count |
| return_bub_o | output | CW | Live return bubble count |
| busy_o | output | 1 | Ratio computation in progress |
| done_o | output | 1 | Ratio outputs valid |
| cpi_o | output | CW+FRAC+2 | CPI, 8 fractional bits |
| load_pen_o | output | CW+FRAC+2 | Load/use penalty per instruction |
| mispredict_pen_o | output | CW+FRAC+2 | Mispredict penalty per instruction |
| return_pen_o | output | CW+FRAC+2 | Return penalty per instruction |

## Verification
The bench builds the block with CW=10 and FRAC=8, keeping the default penalties of 1, 2 and 3. The ten-bit counters let a run of about a thousand cycles drive the instruction counter and the two-per-event mispredict counter into saturation. At 32 bits that point could never be reached. The short dividend also keeps each full four-ratio computation under a hundred cycles, so the worked 1.31 example, uneven remainders, a zero instruction count and a snapshot that arrives while busy all fit in one run.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_KICK = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  localparam int NUM_RATIOS = 4;
  localparam int NUM_CAUSES = 3;
endpackage

// File: rtl/pcnt_rst_sync.sv
module pcnt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/perf_sat_counter.sv
module perf_sat_counter #(
  parameter int W   = 32,
  parameter int INC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hit,
  output logic [W-1:0] count
);
  localparam logic [W:0]   INC_EXT = (W+1)'(INC);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         cnt_en;

  always_comb begin
    sum    = {1'b0, cnt_q} + INC_EXT;
    cnt_en = clr | hit;
    if (clr)         cnt_d = '0;
    else if (sum[W]) cnt_d = MAX_VAL;
    else             cnt_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/perf_seq_divider.sv
module perf_seq_divider #(
  parameter int DW = 42,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          done
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(DW);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [VW-1:0]    rem_q, rem_d;
  logic [DW-1:0]    quo_q, quo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [VW:0]      trial;
  logic             fits;
  logic             step_en;

  always_comb begin
    trial   = {rem_q, quo_q[DW-1]};
    fits    = (trial >= {1'b0, divisor});
    step_en = start | run_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    done_d  = 1'b0;
    if (start) begin
      rem_d = '0;
      quo_d = dividend;
      cnt_d = CNT_INIT;
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = fits ? VW'(trial - {1'b0, divisor}) : trial[VW-1:0];
      quo_d = {quo_q[DW-2:0], fits};
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (step_en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign quotient = quo_q;
  assign done     = done_q;
endmodule

// File: rtl/pipe_perf_counters.sv
module pipe_perf_counters
  import pcnt_pkg::*;
#(
  parameter int CW       = 32,
  parameter int FRAC     = 8,
  parameter int LOAD_PEN = 1,
  parameter int MISP_PEN = 2,
  parameter int RET_PEN  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               snapshot_i,
  input  logic               retire_i,
  input  logic               load_use_i,
  input  logic               mispredict_i,
  input  logic               return_i,
  output logic [CW-1:0]      instr_count_o,
  output logic [CW-1:0]      load_bub_o,
  output logic [CW-1:0]      mispredict_bub_o,
  output logic [CW-1:0]      return_bub_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [CW+FRAC+1:0] cpi_o,
  output logic [CW+FRAC+1:0] load_pen_o,
  output logic [CW+FRAC+1:0] mispredict_pen_o,
  output logic [CW+FRAC+1:0] return_pen_o
);
  localparam int NW = CW + 2;
  localparam int DW = NW + FRAC;
  localparam int PEN [NUM_CAUSES] = '{LOAD_PEN, MISP_PEN, RET_PEN};
  localparam logic [1:0] LAST_IDX = 2'(NUM_RATIOS - 1);

  logic rst_sync_n;

  pcnt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // live counters
  logic [CW-1:0]         instr_cnt;
  logic [CW-1:0]         bub_cnt [NUM_CAUSES];
  logic [NUM_CAUSES-1:0] cause_hit;

  assign cause_hit = {return_i, mispredict_i, load_use_i};

  perf_sat_counter #(.W(CW), .INC(1)) u_instr_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clear_i),
    .hit   (retire_i),
    .count (instr_cnt)
  );

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cause
    perf_sat_counter #(.W(CW), .INC(PEN[g])) u_bub_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clear_i),
      .hit   (cause_hit[g]),
      .count (bub_cnt[g])
    );
  end

  // sequencer
  seq_state_e    state_q, state_d;
  logic [1:0]    idx_q, idx_d;
  logic          done_q, done_d;
  logic          snap_en, div_start, res_we, div_done;
  logic [CW-1:0] snap_q [NUM_RATIOS];
  logic [DW-1:0] res_q  [NUM_RATIOS];
  logic [NW-1:0] numer;
  logic [DW-1:0] quotient;
  logic          den_zero;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    done_d    = done_q;
    snap_en   = 1'b0;
    div_start = 1'b0;
    res_we    = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (snapshot_i) begin
          snap_en = 1'b1;
          idx_d   = '0;
          done_d  = 1'b0;
          state_d = SEQ_KICK;
        end
      end
      SEQ_KICK: begin
        div_start = 1'b1;
        state_d   = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (div_done) begin
          res_we = 1'b1;
          if (idx_q == LAST_IDX) begin
            done_d  = 1'b1;
            state_d = SEQ_IDLE;
          end else begin
            idx_d   = idx_q + 2'd1;
            state_d = SEQ_KICK;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    if (idx_q == 2'd0)
      numer = NW'(snap_q[0]) + NW'(snap_q[1]) + NW'(snap_q[2]) + NW'(snap_q[3]);
    else
      numer = NW'(snap_q[idx_q]);
  end

  assign den_zero = (snap_q[0] == '0);

  perf_seq_divider #(.DW(DW), .VW(CW)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (div_start),
    .dividend ({numer, {FRAC{1'b0}}}),
    .divisor  (snap_q[0]),
    .quotient (quotient),
    .done     (div_done)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_RATIOS; i++) snap_q[i] <= '0;
    end else if (snap_en) begin
      snap_q[0] <= instr_cnt;
      for (int i = 0; i < NUM_CAUSES; i++) snap_q[i+1] <= bub_cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_RATIOS; i++) res_q[i] <= '0;
    end else if (res_we) begin
      res_q[idx_q] <= den_zero ? '0 : quotient;
    end
  end

  assign instr_count_o    = instr_cnt;
  assign load_bub_o       = bub_cnt[0];
  assign mispredict_bub_o = bub_cnt[1];
  assign return_bub_o     = bub_cnt[2];
  assign busy_o           = (state_q != SEQ_IDLE);
  assign done_o           = done_q;
  assign cpi_o            = res_q[0];
  assign load_pen_o       = res_q[1];
  assign mispredict_pen_o = res_q[2];
  assign return_pen_o     = res_q[3];
endmodule

// File: rtl/pipe_perf_counters_chk.sv
module pipe_perf_counters_chk #(
  parameter int CW       = 32,
  parameter int LOAD_PEN = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_i,
  input logic          snapshot_i,
  input logic          retire_i,
  input logic          load_use_i,
  input logic [CW-1:0] instr_count_o,
  input logic [CW-1:0] load_bub_o,
  input logic [CW-1:0] mispredict_bub_o,
  input logic [CW-1:0] return_bub_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] cpi_lsb
);
  localparam logic [CW-1:0] MAX_VAL = {CW{1'b1}};
  localparam logic [CW-1:0] PEN_L   = CW'(LOAD_PEN);

  p_retire_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && retire_i && instr_count_o != MAX_VAL)
      |=> instr_count_o == $past(instr_count_o) + CW'(1));

  p_load_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_use_i && load_bub_o <= MAX_VAL - PEN_L)
      |=> load_bub_o == $past(load_bub_o) + PEN_L);

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && instr_count_o == MAX_VAL) |=> instr_count_o == MAX_VAL);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (instr_count_o == '0 && load_bub_o == '0 &&
                 mispredict_bub_o == '0 && return_bub_o == '0));

  p_snap_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snapshot_i && !busy_o) |=> (busy_o && !done_o));

  p_done_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);

  p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !snapshot_i) |=> (done_o && $stable(cpi_lsb)));
endmodule

bind pipe_perf_counters pipe_perf_counters_chk #(.CW(CW), .LOAD_PEN(LOAD_PEN)) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .clear_i          (clear_i),
  .snapshot_i       (snapshot_i),
  .retire_i         (retire_i),
  .load_use_i       (load_use_i),
  .instr_count_o    (instr_count_o),
  .load_bub_o       (load_bub_o),
  .mispredict_bub_o (mispredict_bub_o),
  .return_bub_o     (return_bub_o),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .cpi_lsb          (cpi_o[CW-1:0])
);

// File: tb/pipe_perf_counters_test.sv
module pipe_perf_counters_test;
  localparam int CW   = 10;
  localparam int FRAC = 8;
  localparam int OW   = CW + FRAC + 2;
  localparam int MAXC = (1 << CW) - 1;
  localparam int NV   = 5;

  // stimulus: retires, load, mispredict, return events; expected ratios
  localparam int V_NR  [NV] = '{100, 4, 3, 7, 0};
  localparam int V_NL  [NV] = '{  9, 1, 0, 2, 1};
  localparam int V_NM  [NV] = '{  8, 1, 0, 0, 0};
  localparam int V_NT  [NV] = '{  2, 1, 0, 1, 0};
  localparam int E_CPI [NV] = '{335, 640, 256, 438, 0};
  localparam int E_PL  [NV] = '{ 23,  64,   0,  73, 0};
  localparam int E_PM  [NV] = '{ 40, 128,   0,   0, 0};
  localparam int E_PT  [NV] = '{ 15, 192,   0, 109, 0};

  logic clk, rst_n, clear_i, snapshot_i, retire_i, load_use_i, mispredict_i, return_i;
  logic [CW-1:0] instr_count_o, load_bub_o, mispredict_bub_o, return_bub_o;
  logic busy_o, done_o;
  logic [OW-1:0] cpi_o, load_pen_o, mispredict_pen_o, return_pen_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  pipe_perf_counters #(.CW(CW), .FRAC(FRAC)) uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .snapshot_i(snapshot_i),
    .retire_i(retire_i), .load_use_i(load_use_i), .mispredict_i(mispredict_i),
    .return_i(return_i), .instr_count_o(instr_count_o), .load_bub_o(load_bub_o),
    .mispredict_bub_o(mispredict_bub_o), .return_bub_o(return_bub_o),
    .busy_o(busy_o), .done_o(done_o), .cpi_o(cpi_o), .load_pen_o(load_pen_o),
    .mispredict_pen_o(mispredict_pen_o), .return_pen_o(return_pen_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      errors = errors + 1;
      checks = checks + 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    clear_i = 0; snapshot_i = 0; retire_i = 0;
    load_use_i = 0; mispredict_i = 0; return_i = 0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    idle_inputs();
    clear_i = 1;
    @(negedge clk);
    clear_i = 0;
  endtask

  task automatic drive_events(input int nr, input int nl, input int nm, input int nt);
    int top;
    top = nr;
    if (nl > top) top = nl;
    if (nm > top) top = nm;
    if (nt > top) top = nt;
    for (int i = 0; i < top; i++) begin
      retire_i     = (i < nr);
      load_use_i   = (i < nl);
      mispredict_i = (i < nm);
      return_i     = (i < nt);
      @(negedge clk);
    end
    idle_inputs();
  endtask

  task automatic pulse_snapshot();
    snapshot_i = 1;
    @(negedge clk);
    snapshot_i = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R1 reset count", int'(instr_count_o), 0);
    chk("R12 reset done", int'(done_o), 0);
    chk("R7 reset busy", int'(busy_o), 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      do_clear();
      drive_events(V_NR[v], V_NL[v], V_NM[v], V_NT[v]);
      chk("R1 instr count", int'(instr_count_o), V_NR[v]);
      chk("R2 load bubbles", int'(load_bub_o), V_NL[v]);
      chk("R3 mispredict bubbles", int'(mispredict_bub_o), 2 * V_NM[v]);
      chk("R4 return bubbles", int'(return_bub_o), 3 * V_NT[v]);
      pulse_snapshot();
      chk("R7 busy after snapshot", int'(busy_o), 1);
      chk("R7 done low after snapshot", int'(done_o), 0);
      wait_done();
      if (V_NR[v] == 0) begin
        chk("R10 zero cpi", int'(cpi_o), 0);
        chk("R10 zero load pen", int'(load_pen_o), 0);
      end else begin
        chk("R8 cpi", int'(cpi_o), E_CPI[v]);
        chk("R9 load pen", int'(load_pen_o), E_PL[v]);
        chk("R9 mispredict pen", int'(mispredict_pen_o), E_PM[v]);
        chk("R9 return pen", int'(return_pen_o), E_PT[v]);
      end
    end

    // R12: results hold while idle and across a clear
    do_clear();
    repeat (5) @(negedge clk);
    chk("R12 done held", int'(done_o), 1);
    chk("R6 clear leaves ratios", int'(cpi_o), 0);
    chk("R6 counts cleared", int'(load_bub_o), 0);

    // R6: clear wins over events in the same cycle
    drive_events(5, 5, 5, 5);
    clear_i = 1; retire_i = 1; load_use_i = 1; mispredict_i = 1; return_i = 1;
    @(negedge clk);
    idle_inputs();
    chk("R6 clear beats retire", int'(instr_count_o), 0);
    chk("R6 clear beats return", int'(return_bub_o), 0);

    // R7: snapshot captures values before the same-edge events
    do_clear();
    drive_events(2, 1, 0, 0);
    snapshot_i = 1; retire_i = 1; load_use_i = 1;
    @(negedge clk);
    idle_inputs();
    chk("R7 live count still advances", int'(instr_count_o), 3);
    wait_done();
    chk("R7 cpi from pre-edge counts", int'(cpi_o), 384);
    chk("R7 load pen from pre-edge counts", int'(load_pen_o), 128);

    // R11: snapshot while busy is ignored
    do_clear();
    drive_events(4, 0, 0, 1);
    pulse_snapshot();
    drive_events(3, 2, 0, 0);
    chk("R11 still busy", int'(busy_o), 1);
    pulse_snapshot();
    wait_done();
    chk("R11 cpi of first snapshot", int'(cpi_o), 448);
    chk("R11 load pen of first snapshot", int'(load_pen_o), 0);
    chk("R11 return pen of first snapshot", int'(return_pen_o), 192);

    // R5: saturation of the instruction and mispredict counters
    do_clear();
    drive_events(MAXC + 6, 0, 520, 0);
    chk("R5 instr saturates", int'(instr_count_o), MAXC);
    chk("R5 mispredict saturates", int'(mispredict_bub_o), MAXC);
    drive_events(0, 0, 0, 400);
    chk("R5 return saturates", int'(return_bub_o), MAXC);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule